// File: doc/BRIEF.md
# Readout Packet Trailer Generator

This block turns a stream of 32-bit event words into level-3 readout packets for an output FIFO. Each event enters as a run of words framed by a start marker on its first word and an end marker on its last word. The first word is already the packet header. The block forwards the header and the payload to the FIFO write port unchanged and in order. Meanwhile it keeps a running word count and a running 32-bit sum. Once the last word has gone through, it appends two trailer words: the count first, then the sum.

A 16-bit qualifier travels beside the stream and is read only with the first word of an event. When its full-readout bit is set, the whole event is written out with its trailer. When the bit is clear, the event is still taken off the input, one word per cycle, but nothing reaches the FIFO. A full FIFO stalls the input only while an event that is being kept needs to write. Words of a kept event are therefore never lost.

The controller has four states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Waits for a start word. |
| `ST_BODY` | Inside an event. |
| `ST_TCNT` | Writes the count trailer word. |
| `ST_TSUM` | Writes the sum trailer word. |

Its transitions are:

| Transition | Condition |
|---|---|
| IDLE→BODY | Start word without end marker. |
| IDLE→TCNT | Kept single-word event. |
| IDLE→IDLE | Dropped single-word event, or stray word. |
| BODY→TCNT | End word of a kept event. |
| BODY→IDLE | End word of a dropped event. |
| TCNT→TSUM | Count word written. |
| TSUM→IDLE | Sum word written. |
| TCNT/TSUM hold | FIFO full. |

Top module: `l3pt_top`

## Requirements
- R1: After reset the block writes nothing to the FIFO, and `in_ready` is high while `fifo_full` is low.
- R2: For an event whose qualifier has bit 0 set on its start word, every word from the start word through the end word is written to the FIFO unchanged and in arrival order. Each word is written in the same cycle in which it is accepted.
- R3: The first trailer word follows the end word of a kept event. It holds the number of words from the start word through the end word, zero-extended to 32 bits. The trailer words themselves are not counted.
- R4: The second trailer word immediately follows the first. It holds the modulo-2^32 sum of all the words counted in R3.
- R5: For an event whose qualifier has bit 0 clear on its start word, no word is written to the FIFO. Every word is accepted in the cycle it is offered, even while `fifo_full` is high.
- R6: A word offered while no event is open and without the start marker is accepted and discarded. It writes nothing and does not disturb the next event.
- R7: No write occurs while `fifo_full` is high. A full FIFO holds off the input of a kept event, and every word of the event still reaches the FIFO afterwards.
- R8: While a trailer is being written, `in_ready` is low. A full FIFO holds the trailer until space appears, and then both trailer words are written.
- R9: An event with the start and end markers on the same word yields that word, then a count of 1, then a sum equal to the word.
- R10: The qualifier is sampled only with the start word. Changes to it later in the event do not change whether the event is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the word this cycle |
| in_data | input | 32 | Event word |
| in_sof | input | 1 | First word of an event |
| in_eof | input | 1 | Last word of an event |
| in_qual | input | 16 | Event qualifier; bit 0 requests full readout |
| fifo_full | input | 1 | Output FIFO cannot take a word |
| fifo_wr_en | output | 1 | Write strobe to output FIFO |
| fifo_wr_data | output | 32 | Word written to output FIFO |

## Verification
Some rules are checked by properties on every cycle:
- No write ever happens into a full FIFO.
- A written word that was accepted in the same cycle equals the input word.
- The input is blocked and held through both trailer states.
- The count word is always followed by the sum state.
- A dropped event never raises the write strobe.

Other behaviour can only be shown by the bench's directed scenarios, because it depends on the contents of a whole event:
- The trailer holds the correct count and sum.
- Late changes to the qualifier and stray words leave the output unchanged.
- Randomly stalled events still come out complete and in order.

// File: rtl/l3pt_pkg.sv
package l3pt_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_TCNT = 2'd2,
        ST_TSUM = 2'd3
    } l3pt_state_e;

    // Output word source
    typedef enum logic [1:0] {
        SEL_PASS = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_SUM  = 2'd2
    } l3pt_sel_e;

endpackage

// File: rtl/l3pt_ctrl.sv
module l3pt_ctrl
    import l3pt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      in_sof,
    input  logic      in_eof,
    input  logic      keep_bit,
    input  logic      fifo_full,
    output logic      in_ready,
    output logic      start,
    output logic      step,
    output logic      wr_en,
    output l3pt_sel_e wr_sel
);

    l3pt_state_e st_q;
    l3pt_state_e st_d;
    logic        keep_q;
    logic        accept;

    // State register and per-event keep flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            keep_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (start) begin
                keep_q <= keep_bit;
            end
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    if (!in_eof)       st_d = ST_BODY;
                    else if (keep_bit) st_d = ST_TCNT;
                    else               st_d = ST_IDLE;
                end
            end
            ST_BODY: begin
                if (accept && in_eof) begin
                    st_d = keep_q ? ST_TCNT : ST_IDLE;
                end
            end
            ST_TCNT: begin
                if (!fifo_full) st_d = ST_TSUM;
            end
            ST_TSUM: begin
                if (!fifo_full) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        in_ready = 1'b0;
        accept   = 1'b0;
        start    = 1'b0;
        step     = 1'b0;
        wr_en    = 1'b0;
        wr_sel   = SEL_PASS;
        unique case (st_q)
            ST_IDLE: begin
                // only a kept start word has to wait for FIFO space
                in_ready = !(in_sof && keep_bit && fifo_full);
                accept   = in_valid && in_ready;
                start    = accept && in_sof;
                wr_en    = start && keep_bit;
            end
            ST_BODY: begin
                in_ready = !(keep_q && fifo_full);
                accept   = in_valid && in_ready;
                step     = accept;
                wr_en    = accept && keep_q;
            end
            ST_TCNT: begin
                wr_sel = SEL_CNT;
                wr_en  = !fifo_full;
            end
            ST_TSUM: begin
                wr_sel = SEL_SUM;
                wr_en  = !fifo_full;
            end
            default: begin
                wr_sel = SEL_PASS;
            end
        endcase
    end

    AST_TRL_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TCNT || st_q == ST_TSUM) |-> !in_ready); // R8

    AST_TRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_TCNT || st_q == ST_TSUM) && fifo_full) |=> (st_q == $past(st_q))); // R8

    AST_CNT_THEN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TCNT && !fifo_full) |=> (st_q == ST_TSUM)); // R4

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BODY && !keep_q) |-> !wr_en); // R5

endmodule

// File: rtl/l3pt_accum.sv
module l3pt_accum #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] sum
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sum <= '0;
        end else if (start) begin
            cnt <= CNT_ONE;
            sum <= data;
        end else if (step) begin
            cnt <= cnt + CNT_ONE;
            sum <= sum + data;
        end
    end

    AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == CNT_ONE)); // R9

endmodule

// File: rtl/l3pt_outmux.sv
module l3pt_outmux
    import l3pt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  l3pt_sel_e         sel,
    input  logic [DATA_W-1:0] pass_data,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] cnt_ext;

    generate
        if (CNT_W < DATA_W) begin : g_pad
            assign cnt_ext = {{(DATA_W - CNT_W){1'b0}}, cnt};
        end else begin : g_trim
            assign cnt_ext = cnt[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_CNT: wr_data = cnt_ext;
            SEL_SUM: wr_data = sum;
            default: wr_data = pass_data;
        endcase
    end

endmodule

// File: rtl/l3pt_top.sv
module l3pt_top
    import l3pt_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          QUAL_W    = 16,
    parameter int          CNT_W     = 16,
    parameter logic [15:0] KEEP_MASK = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [QUAL_W-1:0] in_qual,
    input  logic              fifo_full,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data
);

    localparam logic [QUAL_W-1:0] QMASK = QUAL_W'(KEEP_MASK);

    logic             keep_bit;
    logic             start;
    logic             step;
    l3pt_sel_e        wr_sel;
    logic [CNT_W-1:0] cnt;
    logic [DATA_W-1:0] sum;

    assign keep_bit = |(in_qual & QMASK);

    l3pt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .keep_bit  (keep_bit),
        .fifo_full (fifo_full),
        .in_ready  (in_ready),
        .start     (start),
        .step      (step),
        .wr_en     (fifo_wr_en),
        .wr_sel    (wr_sel)
    );

    l3pt_accum #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .step  (step),
        .data  (in_data),
        .cnt   (cnt),
        .sum   (sum)
    );

    l3pt_outmux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_outmux (
        .sel       (wr_sel),
        .pass_data (in_data),
        .cnt       (cnt),
        .sum       (sum),
        .wr_data   (fifo_wr_data)
    );

    AST_NO_WR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> !fifo_full); // R7

    AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_en && in_valid && in_ready) |-> (fifo_wr_data == in_data)); // R2

endmodule

// File: tb/l3pt_top_tb.sv
`timescale 1ns/1ps
module l3pt_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [15:0] in_qual = '0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr_en;
    logic [31:0] fifo_wr_data;

    int total = 0;
    int bad = 0;
    logic [31:0] cap [0:255];
    int  ncap = 0;
    bit  wr_while_full = 0;
    bit  force_full = 0;
    bit  stall_en = 0;
    int  stall_ph = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    l3pt_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .in_sof       (in_sof),
        .in_eof       (in_eof),
        .in_qual      (in_qual),
        .fifo_full    (fifo_full),
        .fifo_wr_en   (fifo_wr_en),
        .fifo_wr_data (fifo_wr_data)
    );

    // FIFO-side monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && fifo_wr_en) begin
            if (fifo_full) wr_while_full = 1;
            if (ncap < 256) cap[ncap] = fifo_wr_data;
            ncap++;
        end
    end

    // FIFO full generator
    always @(posedge clk) begin
        #2;
        stall_ph++;
        fifo_full = force_full | (stall_en && (stall_ph % 3 != 0));
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(int seed, int i);
        return (seed * 32'h0100_0193) ^ (i * 32'h9E37_79B9) ^ 32'(i + 7);
    endfunction

    task automatic send_word(logic [31:0] d, logic s, logic e, logic [15:0] q,
                             output int waits);
        bit acc;
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e; in_qual = q;
        waits = 0;
        forever begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
            if (acc) break;
            waits++;
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    // Upper qualifier bits are set to show that only bit 0 counts
    task automatic send_event(int len, int seed, logic q_first, logic q_rest,
                              output int waits_total);
        int w;
        waits_total = 0;
        for (int i = 0; i < len; i++) begin
            send_word(word_of(seed, i), i == 0, i == len - 1,
                      {15'h52D2, (i == 0) ? q_first : q_rest}, w);
            waits_total += w;
        end
    endtask

    task automatic expect_packet(int len, int seed, int base, string req);
        logic [31:0] s = '0;
        for (int i = 0; i < len; i++) begin
            check(req, cap[base + i], word_of(seed, i), "payload word");
            s += word_of(seed, i);
        end
        check("R3", cap[base + len], 32'(len), "count trailer");
        check("R4", cap[base + len + 1], s, "sum trailer");
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", {31'd0, fifo_wr_en}, 32'd0, "write strobe after reset");
        check("R1", {31'd0, in_ready}, 32'd1, "ready after reset");
    endtask

    task automatic t_kept_basic();
        int w;
        ncap = 0;
        send_event(5, 11, 1'b1, 1'b1, w);
        @(negedge clk);
        check("R8", {31'd0, in_ready}, 32'd0, "ready during trailer");
        repeat (6) @(posedge clk);
        #1;
        check("R2", 32'(ncap), 32'd7, "kept event word total");
        expect_packet(5, 11, 0, "R2");
    endtask

    task automatic t_dropped();
        int w;
        ncap = 0;
        force_full = 1;
        repeat (2) @(posedge clk);
        #1;
        send_event(6, 23, 1'b0, 1'b0, w);
        check("R5", 32'(w), 32'd0, "stall cycles on dropped event");
        repeat (4) @(posedge clk);
        #1;
        check("R5", 32'(ncap), 32'd0, "writes for dropped event");
        force_full = 0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic t_stray();
        int w;
        ncap = 0;
        send_word(32'hDEAD_0001, 1'b0, 1'b0, 16'h0001, w);
        send_word(32'hDEAD_0002, 1'b0, 1'b1, 16'h0001, w);
        send_word(32'hDEAD_0003, 1'b0, 1'b0, 16'h0001, w);
        repeat (3) @(posedge clk);
        #1;
        check("R6", 32'(ncap), 32'd0, "writes from stray words");
        send_event(2, 31, 1'b1, 1'b1, w);
        repeat (6) @(posedge clk);
        #1;
        check("R6", 32'(ncap), 32'd4, "event after stray words");
        expect_packet(2, 31, 0, "R6");
    endtask

    task automatic t_stall();
        int w;
        ncap = 0;
        wr_while_full = 0;
        stall_en = 1;
        send_event(12, 47, 1'b1, 1'b1, w);
        repeat (40) @(posedge clk);
        #1;
        stall_en = 0;
        check("R7", {31'd0, (w > 0)}, 32'd1, "input held off while full");
        check("R7", {31'd0, wr_while_full}, 32'd0, "write while full");
        check("R7", 32'(ncap), 32'd14, "stalled event word total");
        expect_packet(12, 47, 0, "R7");
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic t_single();
        int w;
        ncap = 0;
        send_event(1, 59, 1'b1, 1'b1, w);
        repeat (5) @(posedge clk);
        #1;
        check("R9", 32'(ncap), 32'd3, "single-word event total");
        check("R9", cap[1], 32'd1, "single-word count");
        check("R9", cap[2], word_of(59, 0), "single-word sum");
    endtask

    task automatic t_qual_late();
        int w;
        ncap = 0;
        send_event(4, 61, 1'b1, 1'b0, w);
        repeat (5) @(posedge clk);
        #1;
        check("R10", 32'(ncap), 32'd6, "kept despite later clear qualifier");
        expect_packet(4, 61, 0, "R10");
        ncap = 0;
        send_event(4, 67, 1'b0, 1'b1, w);
        repeat (5) @(posedge clk);
        #1;
        check("R10", 32'(ncap), 32'd0, "dropped despite later set qualifier");
    endtask

    task automatic t_trailer_full();
        int w;
        ncap = 0;
        send_event(3, 73, 1'b1, 1'b1, w);
        force_full = 1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R8", {31'd0, in_ready}, 32'd0, "ready while trailer held");
        end
        check("R8", 32'(ncap), 32'd3, "no trailer write while full");
        force_full = 0;
        repeat (6) @(posedge clk);
        #1;
        check("R8", 32'(ncap), 32'd5, "trailer after release");
        expect_packet(3, 73, 0, "R8");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        @(posedge clk);
        #1;
        t_kept_basic();
        t_dropped();
        t_stray();
        t_stall();
        t_single();
        t_qual_late();
        t_trailer_full();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule